// File: doc/BRIEF.md
# Dual-Channel DAC Register Controller

This block is the digital control core of a two-channel voltage-output converter. A host sends 24-bit frames over a three-wire serial port: an active-low frame select, a serial clock and a data line. The block oversamples these wires with its own system clock. It decodes a command field, an address field and a 16-bit data field from each frame. Every channel has two registers. The staging register is written by frames. The output register drives the converter code.

Data moves from a staging register to its output register only when the load pin is low. It moves only for channels whose staging register has been written since that channel's last transfer. This lets a host prepare both channels with the load pin high and then update both outputs in the same cycle.

Each channel also holds a power-state setting, which a channel-mask command changes. The block turns that setting into four output-stage controls: amplifier enable, a 1k ground path, a 100k ground path and a floating (high-impedance) output.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After synchronous reset, both output codes are 0, both channels are in normal mode (amp_en = 2'b11), and every ground-path and float control is 0.
- R2: While sync_n is low, a data bit is taken from din at each falling edge of sclk, most significant bit first. Frame bits 23..22 are ignored. Bits 21..19 are the command and bits 18..16 are the address.
- R3: A frame is acted on only if exactly 24 falling edges of sclk arrive before sync_n rises. A frame with fewer or more bits changes nothing.
- R4: Command 000 loads frame bits 15..0 into a staging register. Address 000 selects channel A, 001 selects channel B and 111 selects both. Any other address changes nothing.
- R5: While ldac_n is high, the output codes do not change.
- R6: While ldac_n is low, a written value reaches dac_word within 3 clock cycles after the clock that first samples sync_n high.
- R7: An output register is loaded only on a cycle with ldac_n low, and only if its staging register was written after the last load. When ldac_n falls later, the output takes the latest staged value.
- R8: Command 100 sets the power mode from frame bits 5..4 on each channel whose mask bit is 1 (bit 0 is channel A, bit 1 is channel B). The address field and all other bits are ignored.
- R9: Mode 00 drives amp_en only. Mode 01 drives gnd_1k only, mode 10 drives gnd_100k only and mode 11 drives out_float only. In every mode exactly one of the four controls of a channel is 1.
- R10: A power-mode change never alters an output code. On return to normal mode with ldac_n high, the channel keeps the code it held before power-down. With ldac_n low, it shows its staged value.
- R11: Commands other than 000 and 100 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial bit clock; data taken on its falling edge |
| din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load: staging to output transfer enable |
| dac_word | output | 32 | Output codes, channel A in bits 15..0, channel B in bits 31..16 |
| amp_en | output | 2 | Per-channel amplifier enable (normal mode) |
| gnd_1k | output | 2 | Per-channel 1k ground path enable |
| gnd_100k | output | 2 | Per-channel 100k ground path enable |
| out_float | output | 2 | Per-channel high-impedance output enable |

## Verification
A wrong staging register or a stuck pending flag stays hidden while ldac_n is high. It shows up on dac_word within three cycles of the next ldac_n-low window, as a missing update or a stale code. A bad bit counter or a bad shift register shows up as a frame that is silently dropped or applied to the wrong field. A bad power-mode register shows up on the stage controls in the cycle after the decode. The bench therefore interleaves load-pin toggles with writes and mode changes. After every action it compares all outputs against a model.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;

    localparam int FRAME_BITS = 24;
    localparam int CODE_W     = 16;
    localparam int NUM_CH     = 2;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    localparam logic [2:0] CMD_LOAD_STAGE = 3'b000;
    localparam logic [2:0] CMD_POWER      = 3'b100;

    localparam logic [2:0] ADDR_CH_A  = 3'b000;
    localparam logic [2:0] ADDR_CH_B  = 3'b001;
    localparam logic [2:0] ADDR_CH_AB = 3'b111;

    typedef enum logic [1:0] {
        PWR_NORMAL   = 2'b00,
        PWR_GND_1K   = 2'b01,
        PWR_GND_100K = 2'b10,
        PWR_FLOAT    = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic [1:0]        spare;
        logic [2:0]        cmd;
        logic [2:0]        addr;
        logic [CODE_W-1:0] payload;
    } frame_t;

    typedef struct packed {
        logic amp_en;
        logic gnd_1k;
        logic gnd_100k;
        logic float_out;
    } stage_t;

    typedef struct packed {
        logic [NUM_CH-1:0] stage_wr;
        logic [CODE_W-1:0] code;
        logic [NUM_CH-1:0] pwr_sel;
        pwr_mode_e         pwr_mode;
    } op_t;

    function automatic stage_t stage_of(input pwr_mode_e m);
        stage_t s;
        s = '0;
        unique case (m)
            PWR_NORMAL:   s.amp_en    = 1'b1;
            PWR_GND_1K:   s.gnd_1k    = 1'b1;
            PWR_GND_100K: s.gnd_100k  = 1'b1;
            PWR_FLOAT:    s.float_out = 1'b1;
            default:      s.amp_en    = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dual_dac_rx.sv
module dual_dac_rx
    import dual_dac_pkg::*;
#(
    parameter int N_BITS = FRAME_BITS,
    localparam int C_W   = $clog2(N_BITS + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              din,
    output logic              frame_vld,
    output logic [N_BITS-1:0] frame_bits
);

    localparam logic [C_W-1:0] CNT_FULL = C_W'(N_BITS);
    localparam logic [C_W-1:0] CNT_SAT  = {C_W{1'b1}};

    logic              sclk_q;
    logic              sync_q;
    logic [C_W-1:0]    bit_cnt;
    logic [N_BITS-1:0] shreg;
    logic              sclk_fall;
    logic              sync_rise;

    assign sclk_fall = sclk_q & ~sclk;
    assign sync_rise = ~sync_q & sync_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q     <= 1'b0;
            sync_q     <= 1'b1;
            bit_cnt    <= '0;
            shreg      <= '0;
            frame_vld  <= 1'b0;
            frame_bits <= '0;
        end else begin
            sclk_q    <= sclk;
            sync_q    <= sync_n;
            frame_vld <= 1'b0;
            if (sync_n) begin
                bit_cnt <= '0;
                if (sync_rise && bit_cnt == CNT_FULL) begin
                    frame_vld  <= 1'b1;
                    frame_bits <= shreg;
                end
            end else if (sclk_fall) begin
                shreg <= {shreg[N_BITS-2:0], din};
                if (bit_cnt != CNT_SAT) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dual_dac_decode.sv
module dual_dac_decode
    import dual_dac_pkg::*;
(
    input  logic   frame_vld,
    input  frame_t frame,
    output op_t    op
);

    logic unused_bits;
    assign unused_bits = ^{frame.spare, frame.payload[CODE_W-1:6], frame.payload[3:2]};

    always_comb begin
        op          = '0;
        op.code     = frame.payload;
        op.pwr_mode = pwr_mode_e'(frame.payload[5:4]);
        if (frame_vld) begin
            if (frame.cmd == CMD_LOAD_STAGE) begin
                unique case (frame.addr)
                    ADDR_CH_A:  op.stage_wr = 2'b01;
                    ADDR_CH_B:  op.stage_wr = 2'b10;
                    ADDR_CH_AB: op.stage_wr = 2'b11;
                    default:    op.stage_wr = 2'b00;
                endcase
            end else if (frame.cmd == CMD_POWER) begin
                op.pwr_sel = frame.payload[NUM_CH-1:0];
            end
        end
    end

endmodule

// File: rtl/dual_dac_chan.sv
module dual_dac_chan
    import dual_dac_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ldac_n,
    input  logic         stage_wr,
    input  logic [W-1:0] wr_code,
    input  logic         pwr_sel,
    input  pwr_mode_e    pwr_mode,
    output logic [W-1:0] out_code,
    output stage_t       stage
);

    logic [W-1:0] staged_q;
    logic [W-1:0] out_q;
    logic         pending_q;
    pwr_mode_e    mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q  <= '0;
            out_q     <= '0;
            pending_q <= 1'b0;
            mode_q    <= PWR_NORMAL;
        end else begin
            if (stage_wr) begin
                staged_q  <= wr_code;
                pending_q <= 1'b1;
            end else if (!ldac_n && pending_q) begin
                out_q     <= staged_q;
                pending_q <= 1'b0;
            end
            if (pwr_sel) begin
                mode_q <= pwr_mode;
            end
        end
    end

    assign out_code = out_q;
    assign stage    = stage_of(mode_q);

endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
    import dual_dac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sync_n,
    input  logic                     sclk,
    input  logic                     din,
    input  logic                     ldac_n,
    output logic [NUM_CH*CODE_W-1:0] dac_word,
    output logic [NUM_CH-1:0]        amp_en,
    output logic [NUM_CH-1:0]        gnd_1k,
    output logic [NUM_CH-1:0]        gnd_100k,
    output logic [NUM_CH-1:0]        out_float
);

    logic                  frame_vld;
    logic [FRAME_BITS-1:0] frame_bits;
    op_t                   op;
    stage_t                stg [NUM_CH];

    dual_dac_rx #(.N_BITS(FRAME_BITS)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .sync_n     (sync_n),
        .sclk       (sclk),
        .din        (din),
        .frame_vld  (frame_vld),
        .frame_bits (frame_bits)
    );

    dual_dac_decode u_dec (
        .frame_vld (frame_vld),
        .frame     (frame_t'(frame_bits)),
        .op        (op)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dual_dac_chan #(.W(CODE_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .ldac_n   (ldac_n),
            .stage_wr (op.stage_wr[c]),
            .wr_code  (op.code),
            .pwr_sel  (op.pwr_sel[c]),
            .pwr_mode (op.pwr_mode),
            .out_code (dac_word[c*CODE_W +: CODE_W]),
            .stage    (stg[c])
        );
        assign amp_en[c]    = stg[c].amp_en;
        assign gnd_1k[c]    = stg[c].gnd_1k;
        assign gnd_100k[c]  = stg[c].gnd_100k;
        assign out_float[c] = stg[c].float_out;
    end

endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk
    import dual_dac_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     ldac_n,
    input logic [NUM_CH*CODE_W-1:0] dac_word,
    input logic [NUM_CH-1:0]        amp_en,
    input logic [NUM_CH-1:0]        gnd_1k,
    input logic [NUM_CH-1:0]        gnd_100k,
    input logic [NUM_CH-1:0]        out_float
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dac_word == '0 && amp_en == '1 && gnd_1k == '0
                        && gnd_100k == '0 && out_float == '0));

    // R5
    hold_while_high_chk: assert property (@(posedge clk) disable iff (rst)
        ldac_n |=> $stable(dac_word));

    // R9
    stage_a_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({amp_en[0], gnd_1k[0], gnd_100k[0], out_float[0]}) == 1);

    // R9
    stage_b_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({amp_en[1], gnd_1k[1], gnd_100k[1], out_float[1]}) == 1);

    // R10
    pd_keeps_code_a_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(amp_en[0]) && $past(ldac_n)) |-> $stable(dac_word[CODE_W-1:0]));

    // R10
    pd_keeps_code_b_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(amp_en[1]) && $past(ldac_n)) |-> $stable(dac_word[2*CODE_W-1:CODE_W]));

endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ldac_n    (ldac_n),
    .dac_word  (dac_word),
    .amp_en    (amp_en),
    .gnd_1k    (gnd_1k),
    .gnd_100k  (gnd_100k),
    .out_float (out_float)
);

// File: tb/test_dual_dac_ctrl.sv
module test_dual_dac_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        ldac_n = 1'b1;
    logic [31:0] dac_word;
    logic [1:0]  amp_en, gnd_1k, gnd_100k, out_float;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] m_stage [2];
    logic [15:0] m_out   [2];
    bit          m_pend  [2];
    logic [1:0]  m_mode  [2];

    always #2 clk = ~clk;

    dual_dac_ctrl i_dual_dac_ctrl (
        .clk(clk), .rst(rst), .sync_n(sync_n), .sclk(sclk), .din(din),
        .ldac_n(ldac_n), .dac_word(dac_word), .amp_en(amp_en),
        .gnd_1k(gnd_1k), .gnd_100k(gnd_100k), .out_float(out_float)
    );

    function automatic logic [3:0] exp_stage(input logic [1:0] m);
        case (m)
            2'b00:   return 4'b1000;
            2'b01:   return 4'b0100;
            2'b10:   return 4'b0010;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic [23:0] mk_frame(input logic [1:0] spare, input logic [2:0] cmd,
                                             input logic [2:0] addr, input logic [15:0] data);
        return {spare, cmd, addr, data};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, {32'h0, dac_word}, {32'h0, m_out[1], m_out[0]});
        for (int c = 0; c < 2; c++) begin
            check(req, {60'h0, amp_en[c], gnd_1k[c], gnd_100k[c], out_float[c]},
                  {60'h0, exp_stage(m_mode[c])});
        end
    endtask

    task automatic model_xfer();
        for (int c = 0; c < 2; c++) begin
            if (!ldac_n && m_pend[c]) begin
                m_out[c]  = m_stage[c];
                m_pend[c] = 1'b0;
            end
        end
    endtask

    task automatic model_frame(input logic [23:0] f);
        logic [2:0] cmd;
        logic [2:0] addr;
        logic [1:0] sel;
        cmd  = f[21:19];
        addr = f[18:16];
        sel  = 2'b00;
        if (cmd == 3'b000) begin
            if (addr == 3'b000) sel = 2'b01;
            else if (addr == 3'b001) sel = 2'b10;
            else if (addr == 3'b111) sel = 2'b11;
            for (int c = 0; c < 2; c++) begin
                if (sel[c]) begin
                    m_stage[c] = f[15:0];
                    m_pend[c]  = 1'b1;
                end
            end
        end else if (cmd == 3'b100) begin
            for (int c = 0; c < 2; c++) begin
                if (f[c]) m_mode[c] = f[5:4];
            end
        end
    endtask

    task automatic send(input logic [23:0] f, input int nbits);
        sync_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            din  = (i < 24) ? f[23-i] : 1'b1;
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        sync_n = 1'b1;
        repeat (5) @(negedge clk);
        if (nbits == 24) model_frame(f);
        model_xfer();
    endtask

    task automatic set_ldac(input logic v);
        ldac_n = v;
        repeat (3) @(negedge clk);
        model_xfer();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            m_stage[c] = '0; m_out[c] = '0; m_pend[c] = 1'b0; m_mode[c] = 2'b00;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset state");

        // R5 held while ldac_n high, R4 channel A address
        send(mk_frame(2'b00, 3'b000, 3'b000, 16'h1234), 24);
        check_all("R5 hold with load high");
        // R7 latest staged value taken when load falls
        send(mk_frame(2'b00, 3'b000, 3'b000, 16'h5678), 24);
        set_ldac(1'b0);
        check_all("R7 transfer on load low");
        // R6 follow while low, R2 spare bits ignored, R4 both channels
        send(mk_frame(2'b11, 3'b000, 3'b111, 16'hBEEF), 24);
        check_all("R6 R2 R4 both channels follow");
        // R4 unmapped address
        send(mk_frame(2'b00, 3'b000, 3'b010, 16'h0BAD), 24);
        check_all("R4 unmapped address ignored");
        // R3 wrong lengths
        send(mk_frame(2'b00, 3'b000, 3'b001, 16'h1111), 23);
        check_all("R3 short frame dropped");
        send(mk_frame(2'b00, 3'b000, 3'b001, 16'h2222), 25);
        check_all("R3 long frame dropped");
        // R11 other command
        send(mk_frame(2'b00, 3'b011, 3'b000, 16'h3333), 24);
        check_all("R11 other command ignored");
        // R8 R9 R10 power-down A only with junk bits
        set_ldac(1'b1);
        send(mk_frame(2'b10, 3'b100, 3'b101, 16'hFFDD), 24);
        check_all("R8 R9 channel A 1k only");
        send(mk_frame(2'b00, 3'b000, 3'b000, 16'hCAFE), 24);
        send(mk_frame(2'b00, 3'b100, 3'b000, 16'h0001), 24);
        check_all("R10 normal with load high keeps old code");
        set_ldac(1'b0);
        check_all("R10 load low shows staged code");
        send(mk_frame(2'b00, 3'b100, 3'b000, 16'h0022), 24);
        check_all("R9 channel B 100k");
        send(mk_frame(2'b00, 3'b100, 3'b000, 16'h0033), 24);
        check_all("R9 both float");
        send(mk_frame(2'b00, 3'b000, 3'b111, 16'h4444), 24);
        check_all("R10 powered-down channels still load");

        for (int it = 0; it < 300; it++) begin
            int unsigned r;
            logic [2:0] addr;
            r = $urandom % 10;
            if (r < 5) begin
                case ($urandom % 4)
                    0: addr = 3'b000;
                    1: addr = 3'b001;
                    2: addr = 3'b111;
                    default: addr = 3'($urandom);
                endcase
                send(mk_frame(2'($urandom), 3'b000, addr, 16'($urandom)), 24);
                check_all("R4 R6 random write");
            end else if (r < 7) begin
                send(mk_frame(2'($urandom), 3'b100, 3'($urandom), 16'($urandom)), 24);
                check_all("R8 random power command");
            end else if (r == 7) begin
                set_ldac(1'($urandom));
                check_all("R5 R7 random load level");
            end else if (r == 8) begin
                send(mk_frame(2'b00, 3'b000, 3'b111, 16'($urandom)),
                     ($urandom % 2 == 0) ? 20 + int'($urandom % 4) : 25 + int'($urandom % 3));
                check_all("R3 random bad length");
            end else begin
                logic [2:0] cmd;
                cmd = 3'($urandom);
                if (cmd == 3'b000 || cmd == 3'b100) cmd = 3'b110;
                send(mk_frame(2'b00, cmd, 3'b111, 16'($urandom)), 24);
                check_all("R11 random other command");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule